// File: doc/BRIEF.md
# Y-Extended Saturating Divider

This block is a sequential integer divider for 32-bit divide instructions whose dividend is twice as wide as the result. The 64-bit dividend takes its upper half from a separate high-word register value and its lower half from the low 32 bits of the first operand. The block divides that value by a 32-bit divisor and returns a 64-bit destination value. That value is always a 32-bit quotient, zero-extended in unsigned mode and sign-extended in signed mode. Any quotient that does not fit is clamped to the nearest representable limit instead of wrapping.

A request is one-cycle `start` pulse carrying the mode selects and operands. The block works through one quotient bit per cycle on magnitudes, then applies sign correction and saturation, and reports with a one-cycle `done` pulse. A zero divisor skips the computation. It returns a fault on the next cycle and leaves the previous result in place. When the flag-setting form is requested, an overflow indication accompanies the result.

Top module: `yext_divider`

## Requirements
- R1: The dividend is `{y_hi, opa[31:0]}` as a 64-bit value; bits 63:32 of `opa` have no effect on any output.
- R2: With `is_signed`=0 the quotient is `floor(dividend/divisor)`, zero-extended to 64 bits; if it exceeds 32 bits the result is 0x00000000FFFFFFFF.
- R3: With `is_signed`=1 both dividend and divisor are two's complement, the quotient is truncated toward zero and sign-extended to 64 bits.
- R4: A signed quotient above 2^31-1 (including the most negative dividend divided by -1) gives 0x000000007FFFFFFF.
- R5: A signed quotient below -2^31 gives 0xFFFFFFFF80000000; exactly -2^31 is returned unclamped.
- R6: A zero divisor makes `done` and `div_zero` assert on the first rising edge after the accepting one, `quotient` keeps its previous value and `flags_wr` stays 0.
- R7: `ovf` is 1 with `done` only when saturation (R2, R4 or R5) occurred and `set_flags` was 1; `flags_wr` pulses with `done` when `set_flags` was 1 and no fault occurred.
- R8: For a nonzero divisor, counting the rising edge that accepts `start` as edge 1, `done` asserts after edge 66 (2·W+2).
- R9: `done` is high for exactly one cycle, and `quotient` changes only in a cycle where `done` is high.
- R10: `start` is ignored while a division is in progress; the running result is unaffected and no extra `done` follows.
- R11: After reset `done`, `div_zero`, `ovf`, `flags_wr` are 0 and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| is_signed | input | 1 | 1 selects two's complement division |
| set_flags | input | 1 | 1 selects the flag-producing form |
| y_hi | input | 32 | Upper half of the dividend |
| opa | input | 64 | First operand; low 32 bits form the dividend's lower half |
| divisor | input | 32 | Divisor |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Saturated, extended quotient |
| div_zero | output | 1 | Divide-by-zero fault, with done |
| ovf | output | 1 | Overflow flag, with done |
| flags_wr | output | 1 | Condition flags update strobe, with done |

## Verification
The vectors pair small quotients with ones straddling each limit: unsigned results at exactly 2^31 versus 2^32, signed results at exactly -2^31 versus one below, and 2^31 positive. This separates an off-by-one clamp from a correct one. Mixed-sign operands and a negative dividend with an inexact quotient show whether truncation goes toward zero. The most negative dividend divided by -1 exposes a magnitude that overflows 64-bit signed arithmetic. Garbage in the upper half of the first operand shows it is ignored, and a second start issued mid-division shows it is dropped.

// File: rtl/yext_divider.sv
module yext_divider #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic           set_flags,
  input  logic [W-1:0]   y_hi,
  input  logic [2*W-1:0] opa,
  input  logic [W-1:0]   divisor,
  output logic           done,
  output logic [2*W-1:0] quotient,
  output logic           div_zero,
  output logic           ovf,
  output logic           flags_wr
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [DW-1:0] U_MAX = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [DW-1:0] P_MAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] N_MIN = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [DW-1:0] N_MAG = {{(W+1){1'b0}}, 1'b1, {(W-2){1'b0}}} << 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          busy, fin, sgn_r, sf_r, qneg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  dv, rem;
  logic [DW-1:0] qd;

  wire [DW-1:0] dvd    = {y_hi, opa[W-1:0]};
  wire          dneg   = is_signed & y_hi[W-1];
  wire          vneg   = is_signed & divisor[W-1];
  wire [DW-1:0] dvd_m  = dneg ? -dvd : dvd;
  wire [W-1:0]  dv_m   = vneg ? -divisor : divisor;
  wire          accept = start & ~busy & ~fin;

  wire [W:0] rsh   = {rem, qd[DW-1]};
  wire       ge    = rsh >= {1'b0, dv};
  wire [W:0] rdiff = rsh - {1'b0, dv};
  wire [W-1:0] rem_n = ge ? rdiff[W-1:0] : rsh[W-1:0];

  wire usat = |qd[DW-1:W];
  wire psat = qd > P_MAX;
  wire nsat = qd > N_MAG;
  wire sat  = !sgn_r ? usat : (qneg ? nsat : psat);
  logic [DW-1:0] res;

  always_comb begin
    if (!sgn_r)    res = usat ? U_MAX : qd;
    else if (qneg) res = nsat ? N_MIN : -qd;
    else           res = psat ? P_MAX : qd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fin <= 1'b0; sgn_r <= 1'b0; sf_r <= 1'b0; qneg <= 1'b0;
      cnt <= '0; dv <= '0; rem <= '0; qd <= '0;
      done <= 1'b0; div_zero <= 1'b0; ovf <= 1'b0; flags_wr <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0; div_zero <= 1'b0; ovf <= 1'b0; flags_wr <= 1'b0;
      if (accept) begin
        if (divisor == '0) begin
          done     <= 1'b1;
          div_zero <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cnt   <= '0;
          rem   <= '0;
          qd    <= dvd_m;
          dv    <= dv_m;
          sgn_r <= is_signed;
          sf_r  <= set_flags;
          qneg  <= dneg ^ vneg;
        end
      end else if (busy) begin
        rem <= rem_n;
        qd  <= {qd[DW-2:0], ge};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        fin      <= 1'b0;
        done     <= 1'b1;
        quotient <= res;
        ovf      <= sf_r & sat;
        flags_wr <= sf_r;
      end
    end
  end
endmodule

// File: rtl/yext_divider_chk.sv
module yext_divider_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   divisor,
  input logic           busy,
  input logic           fin,
  input logic           done,
  input logic           div_zero,
  input logic           ovf,
  input logic           flags_wr,
  input logic [2*W-1:0] quotient
);
  localparam logic [2*W-1:0] U_MAX = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [2*W-1:0] P_MAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [2*W-1:0] N_MIN = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(quotient) |-> done);
  // R6
  dz_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !fin && divisor == '0) |=> (done && div_zero && !flags_wr));
  // R6
  dz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) div_zero |-> $stable(quotient));
  // R7
  ovf_done_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> (done && flags_wr && !div_zero));
  // R7
  fwr_chk: assert property (@(posedge clk) disable iff (!rst_n) flags_wr |-> (done && !div_zero));
  // R8
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n) fin |=> (done && !busy));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (busy || fin));
  // R4
  ovf_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (quotient == U_MAX || quotient == P_MAX || quotient == N_MIN));
endmodule

bind yext_divider yext_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .fin(fin), .done(done), .div_zero(div_zero),
  .ovf(ovf), .flags_wr(flags_wr), .quotient(quotient)
);

// File: tb/yext_divider_bench.sv
module yext_divider_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_signed = 1'b0, set_flags = 1'b0;
  logic [31:0] y_hi = '0, divisor = '0;
  logic [63:0] opa = '0;
  logic done, div_zero, ovf, flags_wr;
  logic [63:0] quotient;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  yext_divider u_yext_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .set_flags(set_flags), .y_hi(y_hi), .opa(opa), .divisor(divisor),
    .done(done), .quotient(quotient), .div_zero(div_zero), .ovf(ovf),
    .flags_wr(flags_wr)
  );

  // {signed, set_flags, y, a, d}
  localparam bit [97:0] VEC [0:11] = '{
    {1'b0, 1'b1, 32'h0000_0000, 32'd100,       32'd7},
    {1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'd2},
    {1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 32'h0000_0000, 32'd100,       32'hFFFF_FFF9},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7},
    {1'b1, 1'b1, 32'h0000_0000, 32'h8000_0000, 32'd1},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1},
    {1'b1, 1'b1, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFF9},
    {1'b0, 1'b1, 32'h0000_0000, 32'd5,         32'd10}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void ref_div(input bit sg, input logic [31:0] y, input logic [31:0] a,
                                  input logic [31:0] d, output logic [63:0] q, output bit sat);
    logic [63:0] dd, md, mv, m;
    bit dn, vn;
    dd = {y, a};
    if (!sg) begin
      m = dd / {32'b0, d};
      sat = |m[63:32];
      q = sat ? 64'h0000_0000_FFFF_FFFF : m;
    end else begin
      dn = y[31];
      vn = d[31];
      md = dn ? -dd : dd;
      mv = vn ? -{{32{d[31]}}, d} : {32'b0, d};
      m = md / mv;
      if (dn ^ vn) begin
        sat = m > 64'h8000_0000;
        q = sat ? 64'hFFFF_FFFF_8000_0000 : -m;
      end else begin
        sat = m > 64'h7FFF_FFFF;
        q = sat ? 64'h0000_0000_7FFF_FFFF : m;
      end
    end
  endfunction

  task automatic run(input bit sg, input bit sf, input logic [31:0] y, input logic [63:0] a,
                     input logic [31:0] d, output int lat, output logic [63:0] q,
                     output bit dz, output bit ov, output bit fw);
    @(negedge clk);
    is_signed = sg; set_flags = sf; y_hi = y; opa = a; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    q = quotient; dz = div_zero; ov = ovf; fw = flags_wr;
    @(negedge clk);
    chk("R9 done one cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] q, eq;
    bit dz, ov, fw, sat;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", {63'b0, done}, 64'd0);
    chk("R11 div_zero", {63'b0, div_zero}, 64'd0);
    chk("R11 ovf", {63'b0, ovf}, 64'd0);
    chk("R11 flags_wr", {63'b0, flags_wr}, 64'd0);
    chk("R11 quotient", quotient, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      // R1: upper operand half carries garbage
      run(VEC[i][97], VEC[i][96], VEC[i][95:64], {32'hDEAD_BEEF ^ 32'(i), VEC[i][63:32]},
          VEC[i][31:0], lat, q, dz, ov, fw);
      ref_div(VEC[i][97], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], eq, sat);
      chk(VEC[i][97] ? "R1 R3 R4 R5 signed quotient" : "R1 R2 unsigned quotient", q, eq);
      chk("R7 ovf", {63'b0, ov}, {63'b0, sat & VEC[i][96]});
      chk("R7 flags_wr", {63'b0, fw}, {63'b0, VEC[i][96]});
      chk("R8 latency", 64'(lat), 64'd66);
      chk("R6 no fault", {63'b0, dz}, 64'd0);
    end

    // R5 exactly -2^31 is not clamped
    run(1'b1, 1'b1, 32'hFFFF_FFFF, 64'h0000_0000_8000_0000, 32'd1, lat, q, dz, ov, fw);
    chk("R5 exact min", q, 64'hFFFF_FFFF_8000_0000);
    chk("R5 exact min no ovf", {63'b0, ov}, 64'd0);

    // R4 most negative dividend by -1
    run(1'b1, 1'b1, 32'h8000_0000, 64'd0, 32'hFFFF_FFFF, lat, q, dz, ov, fw);
    chk("R4 min div -1", q, 64'h0000_0000_7FFF_FFFF);
    chk("R4 min div -1 ovf", {63'b0, ov}, 64'd1);

    // R6 zero divisor keeps the previous result (14 from 100/7)
    run(1'b0, 1'b0, 32'd0, 64'd100, 32'd7, lat, q, dz, ov, fw);
    chk("R2 setup 100/7", q, 64'd14);
    run(1'b1, 1'b1, 32'd0, 64'd55, 32'd0, lat, q, dz, ov, fw);
    chk("R6 latency", 64'(lat), 64'd1);
    chk("R6 div_zero", {63'b0, dz}, 64'd1);
    chk("R6 quotient held", q, 64'd14);
    chk("R6 no flags_wr", {63'b0, fw}, 64'd0);
    chk("R6 no ovf", {63'b0, ov}, 64'd0);

    // R10 start while busy is dropped
    @(negedge clk);
    is_signed = 1'b0; set_flags = 1'b0; y_hi = 32'd0; opa = 64'd100; divisor = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    opa = 64'd9; divisor = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 first result kept", quotient, 64'd14);
    lat = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R10 no extra done", 64'(lat), 64'd0);
    chk("R9 quotient unchanged", quotient, 64'd14);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule